// File: doc/BRIEF.md
# Randomized Segmented Thermometer Encoder

This block converts a binary sample for a segmented current-steering converter into the per-element switch controls. The sample splits into an upper 8-bit part and a 4-bit lower part. The upper part is decoded into a unary pattern over a 16x16 array of equal unit elements. Its high nibble selects how many whole rows are on, and its low nibble selects how many cells of the next row are on. The lower part keeps its binary weighting and passes straight through.

To stop element mismatch from locking onto the signal, the unary pattern is cut into groups of eight adjacent elements. Each group goes through an 8-way rotator. All groups share one 3-bit rotation amount, taken from a 16-bit linear feedback shift register that steps on every clock. The same code therefore lights different physical elements from one sample to the next, while the number of lit elements stays the same.

All controls leave the block from one final register stage as true/complement pairs, so every switch changes on the same edge. Latency is two clocks. An internal reset synchronizer asserts the reset at once, whenever the reset pin goes low. It holds the internal reset until the second clock edge after the reset pin goes high again.

Top module: `rand_therm_enc`

## Requirements
- R1: Before rotation, element e = 16*r + c (row r, column c) is on exactly when r < U, or when r == U and c < L, where U = sample_i[11:8] and L = sample_i[7:4].
- R2: The number of ones on msb_en_p_o equals sample_i[11:4] for every sample, from 0 up to 255.
- R3: The elements are cut into groups g of eight, with group g covering indices 8g to 8g+7. For a rotation amount s, output bit 8g+i carries the unrotated element 8g+((i+s) mod 8).
- R4: The rotation amount s is bits [2:0] of a 16-bit shift register. That register resets to 16'hACE1 and, on each update, shifts left and takes bit15^bit13^bit12^bit10 into bit 0. It updates on every clock edge from the third edge after rst_n rises. An output register load uses the register value held just before that same edge.
- R5: All 32 groups use the same rotation amount in the same cycle.
- R6: lsb_p_o equals sample_i[3:0] with no rotation applied.
- R7: A sample present at one rising edge appears on the outputs after the next rising edge. This is two register stages, and the upper and lower parts have equal delay.
- R8: msb_en_n_o is always the bitwise inverse of msb_en_p_o, and lsb_n_o is always the bitwise inverse of lsb_p_o.
- R9: While reset is active, every true output is 0 and every complement output is 1.
- R10: When a nonzero upper code is held constant, the physical elements that are on change from sample to sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 12 | Binary sample: [11:4] unary part, [3:0] binary part |
| msb_en_p_o | output | 256 | Unit element enables, true polarity |
| msb_en_n_o | output | 256 | Unit element enables, complement polarity |
| lsb_p_o | output | 4 | Binary-weighted bits, true polarity |
| lsb_n_o | output | 4 | Binary-weighted bits, complement polarity |

## Verification
A corrupted row or column level shows up two clocks later as a wrong count of lit elements. That count no longer adds up, together with the binary bits, to the sample that went in. A wrong rotation amount or a shift-register state that has drifted keeps the count correct but moves the lit cells. It is caught in the first sample whose exact pattern is compared with the one computed from the shift-register sequence. A stuck shift register shows up within a few samples, because a held code stops moving across the array.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam int          PRN_W    = 16;
  localparam logic [15:0] PRN_SEED = 16'hACE1;

  // Left-shifting feedback register, taps at 16,14,13,11
  function automatic logic [PRN_W-1:0] prn_step(input logic [PRN_W-1:0] s);
    return {s[PRN_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/rte_therm_dec.sv
module rte_therm_dec #(
  parameter int BIN_W = 4,
  localparam int LINES = 1 << BIN_W
) (
  input  logic [BIN_W-1:0] bin_i,
  output logic [LINES-1:0] therm_o
);
  // Line k is high when the binary value is at least k
  for (genvar k = 0; k < LINES; k++) begin : g_line
    localparam logic [BIN_W:0] KV = (BIN_W+1)'(k);
    assign therm_o[k] = ({1'b0, bin_i} >= KV);
  end
endmodule

// File: rtl/rte_elem_matrix.sv
module rte_elem_matrix #(
  parameter int LINES = 16,
  localparam int ELEMS = LINES * LINES
) (
  input  logic [LINES-1:0] row_t_i,
  input  logic [LINES-1:0] col_t_i,
  output logic [ELEMS-1:0] elem_o
);
  logic [LINES-1:0] row_full;
  logic [LINES-1:0] row_edge;
  logic [LINES-1:0] col_below;

  for (genvar r = 0; r < LINES; r++) begin : g_row
    if (r == LINES - 1) begin : g_top
      assign row_full[r]  = 1'b0;
      assign col_below[r] = 1'b0;
    end else begin : g_mid
      assign row_full[r]  = row_t_i[r+1];
      assign col_below[r] = col_t_i[r+1];
    end
    assign row_edge[r] = row_t_i[r] & ~row_full[r];
  end

  for (genvar r = 0; r < LINES; r++) begin : g_r
    for (genvar c = 0; c < LINES; c++) begin : g_c
      assign elem_o[r*LINES + c] = row_full[r] | (row_edge[r] & col_below[c]);
    end
  end
endmodule

// File: rtl/rte_rot_mux.sv
module rte_rot_mux #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [N-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     q_o
);
  logic [SEL_W-1:0] idx;

  always_comb begin
    idx = '0;
    q_o = '0;
    for (int i = 0; i < N; i++) begin
      idx    = SEL_W'(i) + sel_i;
      q_o[i] = d_i[idx];
    end
  end
endmodule

// File: rtl/rte_prn_gen.sv
module rte_prn_gen
  import rte_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEL_W-1:0] sel_o
);
  logic [PRN_W-1:0] state_q, state_d;
  logic             run_q;

  always_comb begin
    state_d = prn_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PRN_SEED;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
    end
  end

  assign sel_o = state_q[SEL_W-1:0];

  AST_PRN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);                                          // R4
  AST_PRN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> state_q != $past(state_q));                    // R4
endmodule

// File: rtl/rand_therm_enc.sv
module rand_therm_enc #(
  parameter int HALF_W = 4,
  parameter int LSB_W  = 4,
  parameter int SEL_W  = 3,
  localparam int MSB_W  = 2 * HALF_W,
  localparam int SMP_W  = MSB_W + LSB_W,
  localparam int LINES  = 1 << HALF_W,
  localparam int ELEMS  = LINES * LINES,
  localparam int GRP_N  = 1 << SEL_W,
  localparam int GROUPS = ELEMS / GRP_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] sample_i,
  output logic [ELEMS-1:0] msb_en_p_o,
  output logic [ELEMS-1:0] msb_en_n_o,
  output logic [LSB_W-1:0] lsb_p_o,
  output logic [LSB_W-1:0] lsb_n_o
);
  // Reset: asserted asynchronously, released on the second edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Stage 1: row/column thermometer decode
  logic [LINES-1:0] row_d, col_d, row_q, col_q;
  logic [LSB_W-1:0] lsb_d, lsb_q;

  rte_therm_dec #(.BIN_W(HALF_W)) u_row_dec (
    .bin_i   (sample_i[SMP_W-1 -: HALF_W]),
    .therm_o (row_d)
  );
  rte_therm_dec #(.BIN_W(HALF_W)) u_col_dec (
    .bin_i   (sample_i[LSB_W +: HALF_W]),
    .therm_o (col_d)
  );
  assign lsb_d = sample_i[LSB_W-1:0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      row_q <= '0;
      col_q <= '0;
      lsb_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      lsb_q <= lsb_d;
    end
  end

  // Stage 2: element map, shared rotation, complementary output
  logic [ELEMS-1:0] elem, scr;
  logic [SEL_W-1:0] sel;

  rte_elem_matrix #(.LINES(LINES)) u_matrix (
    .row_t_i (row_q),
    .col_t_i (col_q),
    .elem_o  (elem)
  );

  rte_prn_gen #(.SEL_W(SEL_W)) u_prn (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel_o (sel)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    rte_rot_mux #(.SEL_W(SEL_W)) u_rot (
      .d_i   (elem[g*GRP_N +: GRP_N]),
      .sel_i (sel),
      .q_o   (scr[g*GRP_N +: GRP_N])
    );
  end

  logic [ELEMS-1:0] msb_p_d, msb_n_d, msb_p_q, msb_n_q;
  logic [LSB_W-1:0] lsb_p_d, lsb_n_d, lsb_p_q, lsb_n_q;

  always_comb begin
    msb_p_d = scr;
    msb_n_d = ~scr;
    lsb_p_d = lsb_q;
    lsb_n_d = ~lsb_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      msb_p_q <= '0;
      msb_n_q <= '1;
      lsb_p_q <= '0;
      lsb_n_q <= '1;
    end else begin
      msb_p_q <= msb_p_d;
      msb_n_q <= msb_n_d;
      lsb_p_q <= lsb_p_d;
      lsb_n_q <= lsb_n_d;
    end
  end

  assign msb_en_p_o = msb_p_q;
  assign msb_en_n_o = msb_n_q;
  assign lsb_p_o    = lsb_p_q;
  assign lsb_n_o    = lsb_n_q;

  // Checker-only fill counter: edges since internal reset release
  logic [1:0] chk_fill_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)              chk_fill_q <= '0;
    else if (chk_fill_q != 2'd3) chk_fill_q <= chk_fill_q + 2'd1;
  end

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (((row_q >> 1) & ~row_q) == '0) && (((col_q >> 1) & ~col_q) == '0)); // R1
  AST_MSB_COUNT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chk_fill_q == 2'd3) |->
      ($countones(msb_p_q) == int'($past(sample_i[SMP_W-1:LSB_W], 2)))); // R2
  AST_LSB_DELAY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chk_fill_q == 2'd3) |-> (lsb_p_q == $past(sample_i[LSB_W-1:0], 2))); // R6
  AST_ROT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chk_fill_q != 2'd0) |-> ($countones(msb_p_q) == $past($countones(elem)))); // R3
endmodule

// File: tb/rand_therm_enc_test.sv
`timescale 1ns/1ps
module rand_therm_enc_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [11:0]  sample;
  logic [255:0] en_p, en_n;
  logic [3:0]   lb_p, lb_n;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rand_therm_enc uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample),
    .msb_en_p_o (en_p),
    .msb_en_n_o (en_n),
    .lsb_p_o    (lb_p),
    .lsb_n_o    (lb_n)
  );

  // Rotation-amount model, built from R4
  logic [15:0] m_prn;
  logic [2:0]  m_used;
  int          m_cnt;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prn  = 16'hACE1;
      m_used = 3'd0;
      m_cnt  = 0;
    end else begin
      if (m_cnt >= 2) begin
        m_used = m_prn[2:0];
        m_prn  = nxt(m_prn);
      end
      if (m_cnt < 3) m_cnt++;
    end
  end

  // Expected pattern from R1, R3, R5
  function automatic logic [255:0] exp_pat(input logic [7:0] v, input logic [2:0] s);
    logic [255:0] u, o;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        u[r*16+c] = (r < int'(v[7:4])) || (r == int'(v[7:4]) && c < int'(v[3:0]));
    for (int g = 0; g < 32; g++)
      for (int i = 0; i < 8; i++)
        o[g*8+i] = u[g*8 + ((i + int'(s)) % 8)];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [11:0] v, input string tag);
    chk(en_p == exp_pat(v[11:4], m_used), {"R1 R3 R5 pattern ", tag}, en_p, exp_pat(v[11:4], m_used));
    chk($countones(en_p) == int'(v[11:4]), {"R2 count ", tag}, 256'($countones(en_p)), 256'(v[11:4]));
    chk(lb_p == v[3:0], {"R6 lsb ", tag}, 256'(lb_p), 256'(v[3:0]));
    chk(en_n == ~en_p && lb_n == ~lb_p, {"R8 complement ", tag}, en_n, ~en_p);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    sample = 12'hFFF;
    repeat (3) @(negedge clk);
    chk(en_p == '0 && lb_p == '0, "R9 true low in reset", en_p, '0);
    chk(en_n == '1 && lb_n == 4'hF, "R9 complement high in reset", en_n, '1);
    rst_n = 1'b1;
    sample = 12'h000;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_single(input logic [11:0] v, input string tag);
    @(negedge clk);
    sample = v;
    repeat (2) @(negedge clk);
    check_all(v, tag);
  endtask

  task automatic t_latency;
    logic [11:0] a;
    a = 12'h5A7;
    @(negedge clk);
    sample = 12'h000;
    repeat (2) @(negedge clk);
    sample = a;
    @(negedge clk);
    chk($countones(en_p) == 0 && lb_p == 4'h0, "R7 not yet after one edge",
        256'($countones(en_p)), 256'(0));
    @(negedge clk);
    chk($countones(en_p) == int'(a[11:4]) && lb_p == a[3:0], "R7 visible after two edges",
        256'($countones(en_p)), 256'(a[11:4]));
  endtask

  task automatic t_stream;
    logic [11:0] hist [40];
    for (int i = 0; i < 40; i++) hist[i] = 12'((i * 977 + 123) & 12'hFFF);
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      if (i >= 2) check_all(hist[i-2], "R7 stream");
      if (i < 40) sample = hist[i];
    end
  endtask

  task automatic t_vary;
    logic [255:0] first;
    bit moved;
    moved = 0;
    @(negedge clk);
    sample = 12'h013;
    repeat (2) @(negedge clk);
    first = en_p;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (en_p != first) moved = 1;
      chk(en_p == exp_pat(8'h01, m_used), "R10 R4 held-code pattern", en_p, exp_pat(8'h01, m_used));
    end
    chk(moved, "R10 elements move", 256'(moved), 256'(1));
  endtask

  initial begin
    #(200000 * 20);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    t_reset();
    t_single(12'h000, "zero");
    t_single(12'hFFF, "full scale");
    t_single(12'h010, "one unit");
    t_single(12'h0F5, "one partial row");
    t_single(12'h100, "one full row");
    t_single(12'h8C3, "mid code");
    t_latency();
    t_stream();
    t_vary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule